// File: doc/BRIEF.md
# A/D Conversion Sequencer

This block decides when a multi-channel analog-to-digital converter samples and which input it samples. Software-style control inputs set a conversion mode, a channel number, a standard start bit and an injected-request bit. The sequencer turns these into a one-cycle start strobe, a channel select and a busy flag for the converter. A small converter model inside the block answers each strobe with a done pulse after a fixed number of cycles.

Four standard modes are offered: one conversion of a fixed channel, endless repetition of a fixed channel, one downward scan, and endless downward scans. A scan begins at the programmed channel and counts down to channel 0. Configuration changes are sampled only at conversion or sequence boundaries. Injected conversions use their own channel input. They wait for a running conversion to end, and they never abort one.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the outputs read as follows: convStart 0, convDone 0, busy 0, injFlag 0 and convChan 0. The sequencer is idle and does nothing until a request arrives.
- R2: Mode code 00 means one conversion of a fixed channel. A rising edge of startBit causes exactly one conversion of chanSel. busy goes high in the same cycle as the strobe. It stays high through the done cycle and drops in the following cycle.
- R3: Mode code 10 means a single downward scan. A start at channel n converts n, n-1, … down to 0, one after another, and then stops with busy low.
- R4: Code 01 repeats conversions of chanSel, and code 11 repeats whole scans that restart at chanSel. Both continue for as long as startBit is 1 when a boundary is reached. In code 11 the only boundary is the end of channel 0.
- R5: Only a 0-to-1 transition of startBit or injReq counts as a request. Holding either bit at 1 starts nothing further.
- R6: A change of modeSel during a conversion takes effect only when that conversion ends. convChan never changes without a start strobe. Switching to a scan code during a fixed conversion of channel n continues with n-1 down to 0.
- R7: In fixed continuous mode, a new chanSel is used from the next conversion. In scan mode, a new chanSel is used only after channel 0 of the current scan.
- R8: A mode change to a scan code while idle, without a rising edge of startBit, starts no conversion.
- R9: A new standard request during a standard conversion aborts that conversion. The new conversion on chanSel is strobed in the next cycle, and the aborted conversion never produces a done pulse.
- R10: An injected request during a standard conversion waits for that conversion's done. It then converts injChanSel with convIsInj high, after which the standard scan resumes where it left off.
- R11: A standard request during an injected conversion is held until the injected conversion completes. It then starts immediately.
- R12: A second injected request during an injected conversion runs right after the first completes. injFlag is 1 from the first request until the first conversion completes, and it reads 0 during the second conversion.
- R13: convDone pulses for one cycle exactly CONV_CYCLES cycles after the cycle in which convStart is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeSel | input | 2 | Mode: bit 1 selects scan, bit 0 selects continuous |
| chanSel | input | CHAN_W | Standard channel / scan start channel |
| startBit | input | 1 | Standard start control, rising edge is a request |
| injReq | input | 1 | Injected request control, rising edge is a request |
| injChanSel | input | CHAN_W | Channel for injected conversions |
| convChan | output | CHAN_W | Channel being converted |
| convStart | output | 1 | One-cycle start strobe to the converter |
| convIsInj | output | 1 | Current conversion is injected |
| convDone | output | 1 | Converter done pulse |
| busy | output | 1 | Standard sequence in progress |
| injFlag | output | 1 | Injected request outstanding |

## Verification
The bench targets several corner cases. One is the unintended start: a design that treats a mode write while idle as a start would produce a scan from channel n-1 with no start edge. Another is abort: a design that lets a standard request wait would show the new channel late, and an aborted conversion would leave a stray done pulse. A third is channel latching inside a scan: if chanSel were used before channel 0, the second scan entry would not be n-1. The last is injected interleaving: a design that got it wrong would cut the standard scan short, start the injected conversion before the boundary, or keep injFlag set through the second injected conversion.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD  = 2'd0,
    SEQ_FRESH = 2'd1,
    SEQ_DEC   = 2'd2
  } seqSel_e;

  typedef enum logic [1:0] {
    FIRE_NONE = 2'd0,
    FIRE_STD  = 2'd1,
    FIRE_INJ  = 2'd2
  } fire_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STD  = 2'd1,
    ST_INJ  = 2'd2
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    seqSel_e seqSel;    // how the scan channel register updates
    fire_e   fire;      // which kind of conversion to strobe
    logic    stdDefer;  // park a standard request behind an injected one
    logic    injFinish; // injected conversion completed
  } seqStrobe_t;

endpackage

// File: rtl/adc_conv_stub.sv
`timescale 1ns/1ps
module adc_conv_stub #(
  parameter int CONV_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic convStart,
  output logic convDone
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rstN)                remain <= '0;
    else if (convStart)       remain <= CNT_W'(CONV_CYCLES);
    else if (remain != '0)    remain <= remain - CNT_W'(1);
  end

  // A restart strobe masks a stale count reaching one
  assign convDone = (remain == CNT_W'(1)) && !convStart;

endmodule

// File: rtl/adc_seq_datapath.sv
`timescale 1ns/1ps
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic [CHAN_W-1:0] injChanSel,
  input  logic              startBit,
  input  logic              injReq,
  input  seqStrobe_t        stb,
  output logic              stdReq,
  output logic              injNew,
  output logic              injPend,
  output logic              stdPend,
  output logic              seqZero,
  output logic [CHAN_W-1:0] convChan,
  output logic              convStart,
  output logic              convIsInj,
  output logic              injFlag
);
  logic              prevStart;
  logic              prevInj;
  logic [CHAN_W-1:0] seqChan;
  logic [CHAN_W-1:0] seqNext;

  assign stdReq  = startBit && !prevStart;
  assign injNew  = injReq && !prevInj;
  assign seqZero = (seqChan == '0);

  always_comb begin
    unique case (stb.seqSel)
      SEQ_FRESH: seqNext = chanSel;
      SEQ_DEC:   seqNext = seqChan - CHAN_W'(1);
      default:   seqNext = seqChan;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevStart <= 1'b0;
      prevInj   <= 1'b0;
      seqChan   <= '0;
      convChan  <= '0;
      convStart <= 1'b0;
      convIsInj <= 1'b0;
      injPend   <= 1'b0;
      stdPend   <= 1'b0;
      injFlag   <= 1'b0;
    end else begin
      prevStart <= startBit;
      prevInj   <= injReq;
      seqChan   <= seqNext;
      convStart <= (stb.fire != FIRE_NONE);
      if (stb.fire == FIRE_STD) begin
        convChan  <= seqNext;
        convIsInj <= 1'b0;
      end else if (stb.fire == FIRE_INJ) begin
        convChan  <= injChanSel;
        convIsInj <= 1'b1;
      end
      if (stb.fire == FIRE_INJ) injPend <= 1'b0;
      else if (injNew)          injPend <= 1'b1;
      if (stb.fire == FIRE_STD && stb.seqSel == SEQ_FRESH) stdPend <= 1'b0;
      else if (stb.stdDefer)                                stdPend <= 1'b1;
      if (injNew)              injFlag <= 1'b1;
      else if (stb.injFinish)  injFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_seq_control.sv
`timescale 1ns/1ps
module adc_seq_control
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       startBit,
  input  logic       stdReq,
  input  logic       injNew,
  input  logic       injPend,
  input  logic       stdPend,
  input  logic       seqZero,
  input  logic       convDone,
  output seqStrobe_t stb,
  output logic       busy
);
  seqState_e state, stateNext;
  logic      busyNext;
  logic      followCont;
  seqSel_e   followSel;

  // What the standard sequence does at a boundary, using the mode seen now
  always_comb begin
    followCont = 1'b0;
    followSel  = SEQ_HOLD;
    if (modeSel[1] && !seqZero) begin
      followCont = 1'b1;
      followSel  = SEQ_DEC;
    end else if (modeSel[0] && startBit) begin
      followCont = 1'b1;
      followSel  = SEQ_FRESH;
    end
  end

  always_comb begin
    stb       = '{seqSel: SEQ_HOLD, fire: FIRE_NONE, stdDefer: 1'b0, injFinish: 1'b0};
    stateNext = state;
    busyNext  = busy;
    unique case (state)
      ST_IDLE: begin
        if (stdReq) begin
          stb.seqSel = SEQ_FRESH;
          stb.fire   = FIRE_STD;
          busyNext   = 1'b1;
          stateNext  = ST_STD;
        end else if (injNew || injPend) begin
          stb.fire  = FIRE_INJ;
          stateNext = ST_INJ;
        end
      end
      ST_STD: begin
        if (stdReq) begin
          stb.seqSel = SEQ_FRESH;
          stb.fire   = FIRE_STD;
        end else if (convDone) begin
          stb.seqSel = followSel;
          busyNext   = followCont;
          if (injPend || injNew) begin
            stb.fire  = FIRE_INJ;
            stateNext = ST_INJ;
          end else if (followCont) begin
            stb.fire = FIRE_STD;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_INJ: begin
        if (convDone) begin
          stb.injFinish = 1'b1;
          if (stdPend || stdReq) begin
            stb.seqSel = SEQ_FRESH;
            stb.fire   = FIRE_STD;
            busyNext   = 1'b1;
            stateNext  = ST_STD;
          end else if (injPend || injNew) begin
            stb.fire = FIRE_INJ;
          end else if (busy) begin
            stb.fire  = FIRE_STD;
            stateNext = ST_STD;
          end else begin
            stateNext = ST_IDLE;
          end
        end else if (stdReq) begin
          stb.stdDefer = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
    end else begin
      state <= stateNext;
      busy  <= busyNext;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W      = 4,
  parameter int CONV_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              startBit,
  input  logic              injReq,
  input  logic [CHAN_W-1:0] injChanSel,
  output logic [CHAN_W-1:0] convChan,
  output logic              convStart,
  output logic              convIsInj,
  output logic              convDone,
  output logic              busy,
  output logic              injFlag
);
  seqStrobe_t stb;
  logic stdReq, injNew, injPend, stdPend, seqZero;

  adc_seq_datapath #(.CHAN_W(CHAN_W)) dp_i (
    .clk(clk), .rstN(rstN), .chanSel(chanSel), .injChanSel(injChanSel),
    .startBit(startBit), .injReq(injReq), .stb(stb),
    .stdReq(stdReq), .injNew(injNew), .injPend(injPend), .stdPend(stdPend),
    .seqZero(seqZero), .convChan(convChan), .convStart(convStart),
    .convIsInj(convIsInj), .injFlag(injFlag)
  );

  adc_seq_control ctl_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .startBit(startBit),
    .stdReq(stdReq), .injNew(injNew), .injPend(injPend), .stdPend(stdPend),
    .seqZero(seqZero), .convDone(convDone), .stb(stb), .busy(busy)
  );

  adc_conv_stub #(.CONV_CYCLES(CONV_CYCLES)) conv_i (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone)
  );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk #(
  parameter int CHAN_W      = 4,
  parameter int CONV_CYCLES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              startBit,
  input logic              convStart,
  input logic              convIsInj,
  input logic              convDone,
  input logic [CHAN_W-1:0] convChan,
  input logic              busy
);
  localparam int AGE_W = $clog2(CONV_CYCLES + 2);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(CONV_CYCLES + 1);

  logic [AGE_W-1:0] sinceStart;

  always_ff @(posedge clk) begin
    if (!rstN)                     sinceStart <= '0;
    else if (convStart)            sinceStart <= AGE_W'(1);
    else if (sinceStart != '0 && sinceStart != AGE_MAX)
                                   sinceStart <= sinceStart + AGE_W'(1);
  end

  assert_done_latency_R13: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> (sinceStart == AGE_W'(CONV_CYCLES)));

  assert_busy_ends_on_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(convDone));

  assert_busy_needs_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(startBit) || $past(convIsInj)));

  assert_inj_waits_boundary_R10: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && convIsInj) |-> (!$past(busy) || $past(convDone)));

  assert_chan_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    !convStart |-> $stable(convChan));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CHAN_W(CHAN_W), .CONV_CYCLES(CONV_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .startBit(startBit), .convStart(convStart),
  .convIsInj(convIsInj), .convDone(convDone), .convChan(convChan), .busy(busy)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  localparam int CHAN_W = 4;
  localparam int CONV_CYCLES = 4;
  localparam int LOG_N = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic [CHAN_W-1:0] chanSel = '0;
  logic startBit = 1'b0;
  logic injReq = 1'b0;
  logic [CHAN_W-1:0] injChanSel = '0;
  logic [CHAN_W-1:0] convChan;
  logic convStart, convIsInj, convDone, busy, injFlag;

  always #10 clk = ~clk;

  adc_seq_ctrl #(.CHAN_W(CHAN_W), .CONV_CYCLES(CONV_CYCLES)) dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .chanSel(chanSel),
    .startBit(startBit), .injReq(injReq), .injChanSel(injChanSel),
    .convChan(convChan), .convStart(convStart), .convIsInj(convIsInj),
    .convDone(convDone), .busy(busy), .injFlag(injFlag)
  );

  int nChecks = 0;
  int nFails = 0;
  int nc = 0;
  int logCount = 0;
  int doneCount = 0;
  int logChan [LOG_N];
  int logInj [LOG_N];
  int logNc [LOG_N];
  int doneNc [LOG_N];
  int cycles = 0;

  always @(negedge clk) begin
    nc = nc + 1;
    if (convStart && logCount < LOG_N) begin
      logChan[logCount] = int'(convChan);
      logInj[logCount]  = int'(convIsInj);
      logNc[logCount]   = nc;
      logCount = logCount + 1;
    end
    if (convDone && doneCount < LOG_N) begin
      doneNc[doneCount] = nc;
      doneCount = doneCount + 1;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 20000) begin
      nChecks = nChecks + 1;
      nFails = nFails + 1;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks = nChecks + 1;
    if (act != exp) begin
      nFails = nFails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearLog();
    logCount = 0;
    doneCount = 0;
  endtask

  task automatic chkSeq(input string tag, input int exp[], input int expInj[]);
    chkEq({tag, " count"}, logCount, exp.size());
    for (int i = 0; i < exp.size() && i < logCount; i++) begin
      chkEq({tag, " channel"}, logChan[i], exp[i]);
      chkEq({tag, " injected"}, logInj[i], expInj[i]);
    end
  endtask

  task automatic testReset();
    chkEq("R1 convStart", int'(convStart), 0);
    chkEq("R1 convDone", int'(convDone), 0);
    chkEq("R1 busy", int'(busy), 0);
    chkEq("R1 injFlag", int'(injFlag), 0);
    chkEq("R1 convChan", int'(convChan), 0);
  endtask

  task automatic testFixedSingle();
    int k;
    clearLog();
    k = nc;
    modeSel = 2'b00; chanSel = 4'd5; startBit = 1'b1;
    step(1);
    chkEq("R2 busy at strobe", int'(busy), 1);
    step(4);
    chkEq("R2 busy in done cycle", int'(busy), 1);
    step(1);
    chkEq("R2 busy after done", int'(busy), 0);
    step(14);
    chkSeq("R2/R5 fixed single held start", '{5}, '{0});
    chkEq("R2 strobe time", logNc[0], k + 1);
    chkEq("R13 done count", doneCount, 1);
    chkEq("R13 done latency", doneNc[0] - logNc[0], CONV_CYCLES);
    startBit = 1'b0;
    step(3);
  endtask

  task automatic testAutoSingle();
    clearLog();
    modeSel = 2'b10; chanSel = 4'd3; startBit = 1'b1;
    step(1); startBit = 1'b0;
    step(30);
    chkSeq("R3 auto single", '{3, 2, 1, 0}, '{0, 0, 0, 0});
    chkEq("R3 spacing", logNc[3] - logNc[0], 3 * (CONV_CYCLES + 1));
    chkEq("R3 busy low", int'(busy), 0);
  endtask

  task automatic testFixedCont();
    int cnt;
    clearLog();
    modeSel = 2'b01; chanSel = 4'd2; startBit = 1'b1;
    step(12); chanSel = 4'd7;
    step(12); startBit = 1'b0;
    step(15);
    chkSeq("R4/R7 fixed continuous", '{2, 2, 2, 7, 7}, '{0, 0, 0, 0, 0});
    chkEq("R4 busy low after stop", int'(busy), 0);
    cnt = logCount;
    step(10);
    chkEq("R4 no strobes after stop", logCount, cnt);
  endtask

  task automatic testAutoCont();
    clearLog();
    modeSel = 2'b11; chanSel = 4'd3; startBit = 1'b1;
    step(3); chanSel = 4'd1;
    step(30); startBit = 1'b0;
    step(30);
    chkSeq("R4/R7 auto continuous", '{3, 2, 1, 0, 1, 0, 1, 0}, '{0, 0, 0, 0, 0, 0, 0, 0});
    chkEq("R4 busy low after scan end", int'(busy), 0);
  endtask

  task automatic testIdleModeSwitch();
    clearLog();
    modeSel = 2'b00; chanSel = 4'd4; startBit = 1'b1;
    step(1); startBit = 1'b0;
    step(10);
    modeSel = 2'b10;
    step(20);
    chkSeq("R8 idle mode switch", '{4}, '{0});
    chkEq("R8 busy stays low", int'(busy), 0);
    startBit = 1'b1;
    step(1); startBit = 1'b0;
    step(30);
    chkSeq("R8 mode with start", '{4, 4, 3, 2, 1, 0}, '{0, 0, 0, 0, 0, 0});
  endtask

  task automatic testModeMid();
    int k;
    clearLog();
    k = nc;
    modeSel = 2'b00; chanSel = 4'd3; startBit = 1'b1;
    step(2); modeSel = 2'b10; startBit = 1'b0;
    step(1);
    chkEq("R6 channel held mid conversion", int'(convChan), 3);
    step(30);
    chkSeq("R6 switch to scan mid conversion", '{3, 2, 1, 0}, '{0, 0, 0, 0});
    chkEq("R6 first strobe", logNc[0], k + 1);
  endtask

  task automatic testAbort();
    int k;
    clearLog();
    k = nc;
    modeSel = 2'b10; chanSel = 4'd5; startBit = 1'b1;
    step(1); startBit = 1'b0;
    step(7);
    chanSel = 4'd9; startBit = 1'b1;
    step(1); startBit = 1'b0;
    step(60);
    chkSeq("R9 abort restart", '{5, 4, 9, 8, 7, 6, 5, 4, 3, 2, 1, 0},
           '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0});
    chkEq("R9 restart strobe time", logNc[2], k + 9);
    chkEq("R9 aborted conversion gives no done", doneCount, 11);
    chkEq("R9 second done is new conversion", doneNc[1], logNc[2] + CONV_CYCLES);
  endtask

  task automatic testInjDuringStd();
    clearLog();
    modeSel = 2'b10; chanSel = 4'd2; startBit = 1'b1;
    step(1); startBit = 1'b0;
    step(1); injChanSel = 4'd11; injReq = 1'b1;
    step(1); injReq = 1'b0;
    step(5);
    chkEq("R10 busy held across injection", int'(busy), 1);
    step(35);
    chkSeq("R10 injected waits and scan resumes", '{2, 11, 1, 0}, '{0, 1, 0, 0});
    chkEq("R10 injected starts at boundary", logNc[1] - logNc[0], CONV_CYCLES + 1);
    chkEq("R10 injFlag cleared", int'(injFlag), 0);
    chkEq("R10 busy low at end", int'(busy), 0);
  endtask

  task automatic testStdDuringInj();
    clearLog();
    modeSel = 2'b00; injChanSel = 4'd6; injReq = 1'b1;
    step(1); injReq = 1'b0;
    step(1); chanSel = 4'd8; startBit = 1'b1;
    step(1); startBit = 1'b0;
    step(30);
    chkSeq("R11 standard waits for injected", '{6, 8}, '{1, 0});
    chkEq("R11 standard starts at injected end", logNc[1] - logNc[0], CONV_CYCLES + 1);
  endtask

  task automatic testInjDuringInj();
    clearLog();
    injChanSel = 4'd1; injReq = 1'b1;
    step(1); injReq = 1'b0;
    chkEq("R12 injFlag set on request", int'(injFlag), 1);
    step(1); injReq = 1'b1;
    step(1); injReq = 1'b0;
    step(5);
    chkEq("R12 injFlag during second", int'(injFlag), 0);
    step(20);
    chkSeq("R12 back to back injected", '{1, 1}, '{1, 1});
    chkEq("R12 second waits", logNc[1] - logNc[0], CONV_CYCLES + 1);
    chkEq("R12 busy never set", int'(busy), 0);
  endtask

  initial begin
    step(4);
    rstN = 1'b1;
    step(1);
    testReset();
    testFixedSingle();
    testAutoSingle();
    testFixedCont();
    testAutoCont();
    testIdleModeSwitch();
    testModeMid();
    testAbort();
    testInjDuringStd();
    testStdDuringInj();
    testInjDuringInj();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule